// File: doc/BRIEF.md
# Cache Program Pipeline Status Tracker

This block tracks a two-stage page program pipeline: a cache register that receives page data from the host, and a data register that feeds the memory array. It models only timing and status, not storage. When the host ends a page load with a cache-program command, the page moves from cache to data register in a short transfer. The cache is then free for the next page while the array programs. If the array is still busy, the transfer is held back until the array goes idle. A normal page-program command ends a load the same way, but the ready/busy pin then waits for the whole pipeline to drain.

The host reads two split readiness bits and two pass/fail bits. One pass/fail bit is for the page most recently handed to the array, and one is for the page before it. A fail outcome is injected per page through an input sampled together with the end-of-load command. The transfer time and the program time are parameters counted in clock cycles.

Top module: `cache_prog_tracker`

## Requirements
- R1: A synchronous reset clears both pipeline stages, all fail flags and the status-read mode. The cycle after reset, `status_o` reads 00h and `rb_n_o` reads 1.
- R2: An end-of-load command is accepted only while the cache is free. The command is byte 15h (cache program) or 10h (page program). Such a command issued while the cache holds a page changes nothing. The same holds for any byte other than 10h, 15h or 70h.
- R3: With the array idle, an accepted page occupies the cache for exactly T_XFER cycles. During that time status bit 6 (cache ready) reads 0.
- R4: While the array is programming, a page waiting in the cache does not begin its transfer. The transfer count starts only once the array is idle, so the cache-busy time stretches by the remaining program time.
- R5: After the transfer, the array programs for exactly T_PROG cycles. Status bit 5 (true ready) reads 1 only when the cache is free and the array is idle.
- R6: After a 15h command, `rb_n_o` follows status bit 6. After a 10h command, `rb_n_o` follows status bit 5. A final 10h after cached pages therefore stays busy through the remaining program time of the earlier page, plus the transfer time, plus its own program time.
- R7: The fail flag stored with a page moves to status bit 0 when that page's transfer completes. At the same moment, the earlier value of bit 0 moves to bit 1.
- R8: Byte 70h enters status-read mode, and an accepted 10h/15h leaves it. In status-read mode the output byte is {wp_n, bit6, bit5, 000, bit1, bit0}. Outside that mode it reads 00h.
- R9: Outputs are registered: `status_o` and `rb_n_o` reflect the pipeline state and `wp_n` one cycle after the clock edge where they were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| fail_in | input | 1 | Fail outcome for the page ended by this command |
| wp_n | input | 1 | Write-protect level, reported in status bit 7 |
| status_o | output | 8 | Status byte in status-read mode, 00h otherwise |
| rb_n_o | output | 1 | Ready (1) / busy (0) |

## Verification
A wrong internal state shows at the ports within one cycle: a transfer counter that slips moves the rise of status bit 6 early or late. A transfer that ignores a busy array makes bit 5 return early and shortens the final busy window. A mis-ordered fail shift swaps bits 0 and 1 at the next transfer. The behavioural model is compared on every clock, so each such fault is caught in the first cycle where the registered outputs differ. Fault-sensitive scenarios include a command issued while the cache is full, a cached page queued behind a long program, and a final page-program command after cached pages.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam logic [7:0] CMD_PAGE   = 8'h10;
  localparam logic [7:0] CMD_CACHE  = 8'h15;
  localparam logic [7:0] CMD_STATUS = 8'h70;
endpackage

// File: rtl/cpt_cache_stage.sv
module cpt_cache_stage #(
  parameter int T_XFER = 4,
  localparam int XW = $clog2(T_XFER + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          arr_idle,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] cnt
);
  // transfer count advances only while the array is idle
  assign done = busy && arr_idle && (cnt == XW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= XW'(T_XFER);
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy && arr_idle) begin
      cnt  <= cnt - XW'(1);
    end
  end
endmodule

// File: rtl/cpt_array_stage.sv
module cpt_array_stage #(
  parameter int T_PROG = 20,
  localparam int PW = $clog2(T_PROG + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic idle
);
  logic [PW-1:0] left;

  assign idle = (left == '0);

  always_ff @(posedge clk) begin
    if (rst)        left <= '0;
    else if (start) left <= PW'(T_PROG);
    else if (!idle) left <= left - PW'(1);
  end
endmodule

// File: rtl/cache_prog_tracker.sv
module cache_prog_tracker
  import cpt_pkg::*;
#(
  parameter int T_XFER = 4,
  parameter int T_PROG = 20,
  localparam int XW = $clog2(T_XFER + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       fail_in,
  input  logic       wp_n,
  output logic [7:0] status_o,
  output logic       rb_n_o
);
  logic          c_busy, x_done, a_idle, accept, is_end;
  logic [XW-1:0] x_cnt;
  logic          cached_mode, rd_mode, pend_fail, cur_fail, prev_fail;
  logic [7:0]    status_now;

  assign is_end = (cmd_byte == CMD_PAGE) || (cmd_byte == CMD_CACHE);
  assign accept = cmd_valid && is_end && !c_busy;

  cpt_cache_stage #(.T_XFER(T_XFER)) u_cache (
    .clk(clk), .rst(rst), .load(accept), .arr_idle(a_idle),
    .busy(c_busy), .done(x_done), .cnt(x_cnt)
  );

  cpt_array_stage #(.T_PROG(T_PROG)) u_array (
    .clk(clk), .rst(rst), .start(x_done), .idle(a_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cached_mode <= 1'b0;
      rd_mode     <= 1'b0;
      pend_fail   <= 1'b0;
    end else if (accept) begin
      cached_mode <= (cmd_byte == CMD_CACHE);
      rd_mode     <= 1'b0;
      pend_fail   <= fail_in;
    end else if (cmd_valid && cmd_byte == CMD_STATUS) begin
      rd_mode     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_fail  <= 1'b0;
      prev_fail <= 1'b0;
    end else if (x_done) begin
      prev_fail <= cur_fail;
      cur_fail  <= pend_fail;
    end
  end

  assign status_now = {wp_n, !c_busy, !c_busy && a_idle, 3'b000, prev_fail, cur_fail};

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= 8'h00;
      rb_n_o   <= 1'b1;
    end else begin
      status_o <= rd_mode ? status_now : 8'h00;
      rb_n_o   <= cached_mode ? status_now[6] : status_now[5];
    end
  end
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int T_XFER = 4,
  localparam int XW = $clog2(T_XFER + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          c_busy,
  input logic          a_idle,
  input logic [XW-1:0] x_cnt,
  input logic [7:0]    status_o
);
  // R8: bits 4..2 never set
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    status_o[4:2] == 3'b000);

  // R5: true ready implies cache ready
  p_true_implies_cache_r5: assert property (@(posedge clk) disable iff (rst)
    status_o[5] |-> status_o[6]);

  // R4: transfer count frozen while the array programs
  p_xfer_waits_r4: assert property (@(posedge clk) disable iff (rst)
    (c_busy && !a_idle) |=> $stable(x_cnt));

  // R3: transfer count bounded by T_XFER
  p_xfer_bound_r3: assert property (@(posedge clk) disable iff (rst)
    x_cnt <= XW'(T_XFER));

  // R5: array starts programming only out of a transfer
  p_prog_from_xfer_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(a_idle) |-> $past(c_busy));
endmodule

bind cache_prog_tracker cpt_checker #(.T_XFER(T_XFER)) u_chk (
  .clk(clk), .rst(rst), .c_busy(c_busy), .a_idle(a_idle),
  .x_cnt(x_cnt), .status_o(status_o)
);

// File: tb/cache_prog_tracker_test.sv
module cache_prog_tracker_test;
  localparam int TX = 4;
  localparam int TP = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic fail_in = 1'b0;
  logic wp_n = 1'b1;
  logic [7:0] status_o;
  logic rb_n_o;

  always #2 clk = ~clk;

  cache_prog_tracker #(.T_XFER(TX), .T_PROG(TP)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .fail_in(fail_in), .wp_n(wp_n), .status_o(status_o), .rb_n_o(rb_n_o)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done_flag = 0;
  string tag = "R1";

  // reference state
  int m_full, m_x, m_p, m_cached, m_rd, m_pend, m_cur, m_prev;
  logic [7:0] e_stat;
  logic e_rb;

  task automatic model_reset();
    m_full = 0; m_x = 0; m_p = 0; m_cached = 0; m_rd = 0;
    m_pend = 0; m_cur = 0; m_prev = 0;
    e_stat = 8'h00; e_rb = 1'b1;
  endtask

  task automatic model_tick();
    logic c_rdy, t_rdy;
    logic [7:0] s;
    c_rdy = (m_full == 0);
    t_rdy = c_rdy && (m_p == 0);
    s = {wp_n, c_rdy, t_rdy, 3'b000, m_prev[0], m_cur[0]};
    e_stat = m_rd ? s : 8'h00;
    e_rb = m_cached ? c_rdy : t_rdy;
    // pipeline advance (R3, R4, R5, R7)
    if (m_full && m_p == 0) begin
      if (m_x == 1) begin
        m_full = 0; m_p = TP; m_prev = m_cur; m_cur = m_pend;
      end else m_x--;
    end else if (m_p > 0) m_p--;
    // commands (R2, R8)
    if (cmd_valid && (cmd_byte == 8'h10 || cmd_byte == 8'h15) && c_rdy) begin
      m_full = 1; m_x = TX; m_cached = (cmd_byte == 8'h15);
      m_rd = 0; m_pend = fail_in;
    end else if (cmd_valid && cmd_byte == 8'h70) m_rd = 1;
  endtask

  task automatic compare();
    checks++;
    if (status_o !== e_stat || rb_n_o !== e_rb) begin
      fails++;
      $display("FAIL %s cycle %0d: status=%h rb=%b expected status=%h rb=%b",
               tag, cycles, status_o, rb_n_o, e_stat, e_rb);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] b, input logic f);
    cmd_valid = v; cmd_byte = b; fail_in = f;
    if (rst) model_reset(); else model_tick();
    @(negedge clk);
    cycles++;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    if (!done_flag) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    tag = "R1 reset";
    rst = 1'b1; step(0, 8'h00, 0); step(0, 8'h00, 0);
    rst = 1'b0; step(0, 8'h00, 0);

    tag = "R8 idle status";      // expect E0h after 70h
    step(1, 8'h70, 0); idle(2);
    wp_n = 1'b0; idle(2); wp_n = 1'b1;

    tag = "R6 page program";
    step(1, 8'h10, 1); step(1, 8'h70, 0);
    idle(TX + TP + 3);

    tag = "R3 cache program";
    step(1, 8'h15, 0); step(1, 8'h70, 0); idle(1);
    tag = "R2 ignored while cache full";
    step(1, 8'h15, 1); step(1, 8'h10, 1); step(1, 8'h33, 0); idle(TX);

    tag = "R4 queued transfer";
    step(1, 8'h15, 1); step(1, 8'h70, 0);
    idle(8);
    tag = "R6 final page after cached";
    idle(TP);
    step(1, 8'h10, 0); step(1, 8'h70, 0);
    tag = "R7 fail shift";
    idle(2 * TP + 2 * TX + 6);

    tag = "R9 back to back";
    step(1, 8'h15, 1); idle(TX); step(1, 8'h15, 0); idle(TX);
    step(1, 8'h10, 1); step(1, 8'h70, 0);
    idle(3 * TP + 3 * TX + 4);

    tag = "R1 reset mid-run";
    step(1, 8'h15, 1); idle(3);
    rst = 1'b1; step(0, 8'h00, 0);
    rst = 1'b0; step(0, 8'h00, 0); step(1, 8'h70, 0); idle(3);

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule